// File: doc/BRIEF.md
# Temperature Alarm Event Controller

This block watches a signed temperature word and decides when a thermal event is raised. Software programs an upper and a lower alarm limit and a critical limit. It also selects a hysteresis step, an event mode, the level at which the pin is active and whether the pin is driven at all. Every clock cycle, the block compares the sample against the three limits. It keeps one flag for above the window, one for below the window and one for critical. From these flags it derives an event status bit and the level of the event pin.

The temperature input counts sixteenths of a degree in two's complement. Before any comparison, the block drops its two lowest bits to reach quarter-degree resolution. The three limit registers hold a quarter-degree value in bits 12:2. Writes go through one shared data bus, with one strobe per register. Two lock bits protect the limits and the event mode and polarity against later writes. A shutdown bit stops evaluation without losing the current state.

Top module: `tsev_alarm_ctrl`

## Requirements
- R1: After reset, all three flags and the event status are 0 and every readback word is 0. The pin is high: the pin is disabled and the polarity is active low.
- R2: A limit write stores data bits 12:2, and its readback has bits 15:13 and 1:0 at zero. Bits 12:2 form a signed count of quarter degrees.
- R3: The above flag sets when the scaled temperature is greater than the upper limit. It clears only when the temperature is below the upper limit minus the hysteresis. Config bits 10:9 select the hysteresis: 0 gives 0, 1 gives 6, 2 gives 12 and 3 gives 24 quarter-degree units.
- R4: The below flag sets when the scaled temperature is below the lower limit minus the hysteresis. It clears when the temperature is greater than or equal to the lower limit.
- R5: The critical flag sets when the temperature is greater than the critical limit and clears below the critical limit minus the hysteresis. While it is set, the event status is 1 in every mode, and a clear has no effect.
- R6: In comparator mode (config bit 0 = 0), the event status equals the OR of the three flags, and a clear has no effect.
- R7: In interrupt mode (config bit 0 = 1), a latch sets in any cycle where the above or below flag goes from 0 to 1. The latch stays set until a clear, which is either the clear input or a config write with bit 5 = 1. If a set and a clear fall in the same cycle, the set wins.
- R8: With critical-only set (config bit 2), only the critical flag can raise the event status.
- R9: With output enable set (config bit 3), the pin equals the event status when polarity (config bit 1) is 1, and its inverse when polarity is 0. With output enable clear, the pin sits at its inactive level, which is the inverse of the polarity bit.
- R10: Config bit 6 locks the alarm limits and config bit 7 locks the critical limit. A locked limit ignores writes. While either lock is set, config writes leave bits 0 and 1 unchanged. A lock bit clears only on reset. The config readback has the event status in bit 4, and bit 5 reads as 0.
- R11: While shutdown (config bit 8) is set, the flags, the interrupt latch and the event status hold their values, and a clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_i | input | 16 | Temperature sample, signed, 1/16 degree per LSB |
| wdata_i | input | 16 | Register write data |
| cfg_we_i | input | 1 | Config register write strobe |
| upper_we_i | input | 1 | Upper alarm limit write strobe |
| lower_we_i | input | 1 | Lower alarm limit write strobe |
| crit_we_i | input | 1 | Critical limit write strobe |
| clr_evt_i | input | 1 | Clear strobe for the interrupt latch |
| cfg_rd_o | output | 16 | Config readback with event status in bit 4 |
| upper_rd_o | output | 16 | Upper limit readback |
| lower_rd_o | output | 16 | Lower limit readback |
| crit_rd_o | output | 16 | Critical limit readback |
| above_o | output | 1 | Above-window flag |
| below_o | output | 1 | Below-window flag |
| crit_o | output | 1 | Critical flag |
| evt_status_o | output | 1 | Event status |
| evt_pin_o | output | 1 | Event pin level |

## Verification
Each flag holds its own hysteresis state. A flag stuck in the wrong state therefore shows on its output one edge after a sample that should have moved it, and it stays wrong until the opposite threshold is crossed. A stale interrupt latch keeps the event status and the pin asserted across an explicit clear. The sweeps therefore ramp the temperature up and down at every hysteresis setting and compare flags, status, pin and readbacks after every edge. A lock or shutdown fault shows at once in the config readback, or in flags that move when they should hold.

// File: rtl/tsev_pkg.sv
package tsev_pkg;

    // Bit positions within the configuration word
    localparam int CB_MODE  = 0;
    localparam int CB_POL   = 1;
    localparam int CB_CONLY = 2;
    localparam int CB_OE    = 3;
    localparam int CB_STAT  = 4;
    localparam int CB_CLR   = 5;
    localparam int CB_LKA   = 6;
    localparam int CB_LKC   = 7;
    localparam int CB_SHDN  = 8;
    localparam int CB_HYLO  = 9;
    localparam int CB_HYHI  = 10;

    typedef struct packed {
        logic [1:0] hyst;
        logic       shdn;
        logic       lock_c;
        logic       lock_a;
        logic       oe;
        logic       conly;
        logic       pol;
        logic       mode;
    } tsev_cfg_t;

    // Flag vector indices
    localparam int FL_ABOVE = 0;
    localparam int FL_BELOW = 1;
    localparam int FL_CRIT  = 2;

endpackage

// File: rtl/tsev_cfg_regs.sv
module tsev_cfg_regs
    import tsev_pkg::*;
#(
    parameter int DW      = 16,
    parameter int LIM_LSB = 2,
    parameter int LIM_MSB = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] wdata,
    input  logic          cfg_we,
    input  logic          upper_we,
    input  logic          lower_we,
    input  logic          crit_we,
    output tsev_cfg_t     cfg,
    output logic [DW-1:0] upper_w,
    output logic [DW-1:0] lower_w,
    output logic [DW-1:0] crit_w
);

    localparam logic [DW-1:0] LIM_MASK =
        DW'(((1 << (LIM_MSB - LIM_LSB + 1)) - 1) << LIM_LSB);

    typedef struct packed {
        tsev_cfg_t     cfg;
        logic [DW-1:0] up;
        logic [DW-1:0] lo;
        logic [DW-1:0] cr;
    } regs_t;

    regs_t r_d, r_q;
    logic  any_lock;

    always_comb begin
        r_d      = r_q;
        any_lock = r_q.cfg.lock_a | r_q.cfg.lock_c;
        if (cfg_we) begin
            if (!any_lock) begin
                r_d.cfg.mode = wdata[CB_MODE];
                r_d.cfg.pol  = wdata[CB_POL];
            end
            r_d.cfg.conly  = wdata[CB_CONLY];
            r_d.cfg.oe     = wdata[CB_OE];
            r_d.cfg.lock_a = r_q.cfg.lock_a | wdata[CB_LKA];
            r_d.cfg.lock_c = r_q.cfg.lock_c | wdata[CB_LKC];
            r_d.cfg.shdn   = wdata[CB_SHDN];
            r_d.cfg.hyst   = wdata[CB_HYHI:CB_HYLO];
        end
        if (upper_we && !r_q.cfg.lock_a) r_d.up = wdata & LIM_MASK;
        if (lower_we && !r_q.cfg.lock_a) r_d.lo = wdata & LIM_MASK;
        if (crit_we  && !r_q.cfg.lock_c) r_d.cr = wdata & LIM_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg     = r_q.cfg;
    assign upper_w = r_q.up;
    assign lower_w = r_q.lo;
    assign crit_w  = r_q.cr;

    a_r10_mode_pol_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (r_q.cfg.lock_a || r_q.cfg.lock_c))
            |=> ($stable(r_q.cfg.mode) && $stable(r_q.cfg.pol)));

    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cfg.lock_a |=> r_q.cfg.lock_a);

    a_r10_upper_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (upper_we && r_q.cfg.lock_a) |=> $stable(r_q.up));

endmodule

// File: rtl/tsev_window_cmp.sv
module tsev_window_cmp
    import tsev_pkg::*;
#(
    parameter int TEMP_W  = 16,
    parameter int DW      = 16,
    parameter int LIM_LSB = 2,
    parameter int LIM_MSB = 12,
    parameter int HYST1   = 6,
    parameter int HYST2   = 12,
    parameter int HYST3   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp,
    input  logic [DW-1:0]     upper_w,
    input  logic [DW-1:0]     lower_w,
    input  logic [DW-1:0]     crit_w,
    input  logic [1:0]        hyst,
    input  logic              shdn,
    output logic [2:0]        flg_nxt,
    output logic [2:0]        flg_q
);

    localparam int CMP_W = TEMP_W + 2;
    localparam int LIM_W = LIM_MSB - LIM_LSB + 1;

    typedef logic signed [CMP_W-1:0] cval_t;

    cval_t      t_s, up_s, lo_s, cr_s, h_s;
    logic [2:0] flg_d;

    function automatic cval_t lim_val(input logic [DW-1:0] w);
        logic signed [LIM_W-1:0] f;
        f = w[LIM_MSB:LIM_LSB];
        return cval_t'(f);
    endfunction

    always_comb begin
        t_s  = cval_t'($signed(temp[TEMP_W-1:2]));
        up_s = lim_val(upper_w);
        lo_s = lim_val(lower_w);
        cr_s = lim_val(crit_w);
        case (hyst)
            2'd1:    h_s = cval_t'(HYST1);
            2'd2:    h_s = cval_t'(HYST2);
            2'd3:    h_s = cval_t'(HYST3);
            default: h_s = '0;
        endcase

        flg_d = flg_q;
        if (!shdn) begin
            if (flg_q[FL_ABOVE]) flg_d[FL_ABOVE] = !(t_s < (up_s - h_s));
            else                 flg_d[FL_ABOVE] = (t_s > up_s);
            if (flg_q[FL_BELOW]) flg_d[FL_BELOW] = !(t_s >= lo_s);
            else                 flg_d[FL_BELOW] = (t_s < (lo_s - h_s));
            if (flg_q[FL_CRIT])  flg_d[FL_CRIT]  = !(t_s < (cr_s - h_s));
            else                 flg_d[FL_CRIT]  = (t_s > cr_s);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flg_nxt = flg_d;

    a_r11_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |=> $stable(flg_q));

endmodule

// File: rtl/tsev_event_gen.sv
module tsev_event_gen
    import tsev_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tsev_cfg_t cfg,
    input  logic [2:0] flg_nxt,
    input  logic [2:0] flg_q,
    input  logic      clr,
    output logic      evt_q,
    output logic      pin
);

    typedef struct packed {
        logic latch;
        logic evt;
    } ev_t;

    ev_t  e_d, e_q;
    logic rise;
    logic win;

    always_comb begin
        e_d  = e_q;
        rise = (flg_nxt[FL_ABOVE] & ~flg_q[FL_ABOVE])
             | (flg_nxt[FL_BELOW] & ~flg_q[FL_BELOW]);
        win  = 1'b0;
        if (!cfg.shdn) begin
            if (rise)     e_d.latch = 1'b1;
            else if (clr) e_d.latch = 1'b0;
            win   = cfg.mode ? e_d.latch
                             : (flg_nxt[FL_ABOVE] | flg_nxt[FL_BELOW]);
            e_d.evt = flg_nxt[FL_CRIT] | (~cfg.conly & win);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign evt_q = e_q.evt;
    assign pin   = cfg.oe ? (cfg.pol ? e_q.evt : ~e_q.evt) : ~cfg.pol;

    a_r5_crit_forces_event: assert property (@(posedge clk) disable iff (!rst_n)
        flg_q[FL_CRIT] |-> evt_q);

    a_r6_comparator_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.mode && !cfg.conly && !cfg.shdn) |=> (evt_q == (|flg_q)));

    a_r8_crit_only_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.conly && !cfg.shdn) |=> (evt_q == flg_q[FL_CRIT]));

endmodule

// File: rtl/tsev_alarm_ctrl.sv
module tsev_alarm_ctrl
    import tsev_pkg::*;
#(
    parameter int TEMP_W  = 16,
    parameter int DW      = 16,
    parameter int LIM_LSB = 2,
    parameter int LIM_MSB = 12,
    parameter int HYST1   = 6,
    parameter int HYST2   = 12,
    parameter int HYST3   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic              cfg_we_i,
    input  logic              upper_we_i,
    input  logic              lower_we_i,
    input  logic              crit_we_i,
    input  logic              clr_evt_i,
    output logic [DW-1:0]     cfg_rd_o,
    output logic [DW-1:0]     upper_rd_o,
    output logic [DW-1:0]     lower_rd_o,
    output logic [DW-1:0]     crit_rd_o,
    output logic              above_o,
    output logic              below_o,
    output logic              crit_o,
    output logic              evt_status_o,
    output logic              evt_pin_o
);

    tsev_cfg_t  cfg;
    logic [2:0] flg_nxt, flg_q;
    logic       clr, evt;

    assign clr = clr_evt_i | (cfg_we_i & wdata_i[CB_CLR]);

    tsev_cfg_regs #(.DW(DW), .LIM_LSB(LIM_LSB), .LIM_MSB(LIM_MSB)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wdata    (wdata_i),
        .cfg_we   (cfg_we_i),
        .upper_we (upper_we_i),
        .lower_we (lower_we_i),
        .crit_we  (crit_we_i),
        .cfg      (cfg),
        .upper_w  (upper_rd_o),
        .lower_w  (lower_rd_o),
        .crit_w   (crit_rd_o)
    );

    tsev_window_cmp #(
        .TEMP_W(TEMP_W), .DW(DW), .LIM_LSB(LIM_LSB), .LIM_MSB(LIM_MSB),
        .HYST1(HYST1), .HYST2(HYST2), .HYST3(HYST3)
    ) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .temp    (temp_i),
        .upper_w (upper_rd_o),
        .lower_w (lower_rd_o),
        .crit_w  (crit_rd_o),
        .hyst    (cfg.hyst),
        .shdn    (cfg.shdn),
        .flg_nxt (flg_nxt),
        .flg_q   (flg_q)
    );

    tsev_event_gen u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .flg_nxt (flg_nxt),
        .flg_q   (flg_q),
        .clr     (clr),
        .evt_q   (evt),
        .pin     (evt_pin_o)
    );

    always_comb begin
        cfg_rd_o            = '0;
        cfg_rd_o[CB_MODE]   = cfg.mode;
        cfg_rd_o[CB_POL]    = cfg.pol;
        cfg_rd_o[CB_CONLY]  = cfg.conly;
        cfg_rd_o[CB_OE]     = cfg.oe;
        cfg_rd_o[CB_STAT]   = evt;
        cfg_rd_o[CB_LKA]    = cfg.lock_a;
        cfg_rd_o[CB_LKC]    = cfg.lock_c;
        cfg_rd_o[CB_SHDN]   = cfg.shdn;
        cfg_rd_o[CB_HYHI:CB_HYLO] = cfg.hyst;
    end

    assign above_o      = flg_q[FL_ABOVE];
    assign below_o      = flg_q[FL_BELOW];
    assign crit_o       = flg_q[FL_CRIT];
    assign evt_status_o = evt;

    a_r9_disabled_pin_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rd_o[CB_OE]) |-> (evt_pin_o == ~cfg_rd_o[CB_POL]));

endmodule

// File: tb/tb_tsev_alarm_ctrl.sv
module tb_tsev_alarm_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] temp_i = '0, wdata_i = '0;
    logic        cfg_we_i = 0, upper_we_i = 0, lower_we_i = 0, crit_we_i = 0, clr_evt_i = 0;
    logic [15:0] cfg_rd_o, upper_rd_o, lower_rd_o, crit_rd_o;
    logic        above_o, below_o, crit_o, evt_status_o, evt_pin_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    string cur_req = "R6";

    // bench model state
    bit m_mode, m_pol, m_conly, m_oe, m_lka, m_lkc, m_shdn;
    logic [1:0] m_hyst;
    logic [15:0] m_up, m_lo, m_cr;
    bit m_above, m_below, m_crit, m_latch, m_evt;

    always #2.5 clk = ~clk;

    tsev_alarm_ctrl dut (
        .clk(clk), .rst_n(rst_n), .temp_i(temp_i), .wdata_i(wdata_i),
        .cfg_we_i(cfg_we_i), .upper_we_i(upper_we_i), .lower_we_i(lower_we_i),
        .crit_we_i(crit_we_i), .clr_evt_i(clr_evt_i),
        .cfg_rd_o(cfg_rd_o), .upper_rd_o(upper_rd_o), .lower_rd_o(lower_rd_o),
        .crit_rd_o(crit_rd_o), .above_o(above_o), .below_o(below_o),
        .crit_o(crit_o), .evt_status_o(evt_status_o), .evt_pin_o(evt_pin_o)
    );

    function automatic int lim(input logic [15:0] w);
        logic signed [10:0] s;
        s = w[12:2];
        return int'(s);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int t, h, u, l, c;
        bit na, nb, nc, rise, clr;
        if (!m_shdn) begin
            t = int'($signed(temp_i)) >>> 2;
            h = (m_hyst == 0) ? 0 : (m_hyst == 1) ? 6 : (m_hyst == 2) ? 12 : 24;
            u = lim(m_up); l = lim(m_lo); c = lim(m_cr);
            na = m_above ? !(t < u - h) : (t > u);
            nb = m_below ? !(t >= l)    : (t < l - h);
            nc = m_crit  ? !(t < c - h) : (t > c);
            rise = (na && !m_above) || (nb && !m_below);
            clr = clr_evt_i || (cfg_we_i && wdata_i[5]);
            if (rise) m_latch = 1;
            else if (clr) m_latch = 0;
            m_evt = nc || (!m_conly && (m_mode ? m_latch : (na || nb)));
            m_above = na; m_below = nb; m_crit = nc;
        end
        if (cfg_we_i) begin
            if (!(m_lka || m_lkc)) begin
                m_mode = wdata_i[0]; m_pol = wdata_i[1];
            end
            m_conly = wdata_i[2]; m_oe = wdata_i[3];
            if (upper_we_i && !m_lka) m_up = wdata_i & 16'h1FFC;
            if (lower_we_i && !m_lka) m_lo = wdata_i & 16'h1FFC;
            if (crit_we_i && !m_lkc)  m_cr = wdata_i & 16'h1FFC;
            m_lka = m_lka || wdata_i[6]; m_lkc = m_lkc || wdata_i[7];
            m_shdn = wdata_i[8]; m_hyst = wdata_i[10:9];
        end else begin
            if (upper_we_i && !m_lka) m_up = wdata_i & 16'h1FFC;
            if (lower_we_i && !m_lka) m_lo = wdata_i & 16'h1FFC;
            if (crit_we_i && !m_lkc)  m_cr = wdata_i & 16'h1FFC;
        end
    endtask

    task automatic check_all();
        logic [15:0] ecfg;
        bit epin;
        ecfg = {5'b0, m_hyst, m_shdn, m_lkc, m_lka, 1'b0, m_evt, m_oe, m_conly, m_pol, m_mode};
        epin = m_oe ? (m_pol ? m_evt : !m_evt) : !m_pol;
        chk("R3", "above", 16'(above_o), 16'(m_above));
        chk("R4", "below", 16'(below_o), 16'(m_below));
        chk("R5", "crit", 16'(crit_o), 16'(m_crit));
        chk(cur_req, "evt_status", 16'(evt_status_o), 16'(m_evt));
        chk("R9", "pin", 16'(evt_pin_o), 16'(epin));
        chk("R10", "cfg_rd", cfg_rd_o, ecfg);
        chk("R2", "upper_rd", upper_rd_o, m_up);
        chk("R2", "lower_rd", lower_rd_o, m_lo);
        chk("R2", "crit_rd", crit_rd_o, m_cr);
    endtask

    // inputs are set before calling; clocks one edge, checks, then idles strobes
    task automatic tick();
        @(posedge clk);
        #1;
        model_edge();
        check_all();
        @(negedge clk);
        cfg_we_i = 0; upper_we_i = 0; lower_we_i = 0; crit_we_i = 0; clr_evt_i = 0;
    endtask

    task automatic wr_cfg(input logic [15:0] v);
        wdata_i = v; cfg_we_i = 1; tick();
    endtask

    task automatic wr_lim(input int sel, input logic [15:0] v);
        wdata_i = v;
        upper_we_i = (sel == 0); lower_we_i = (sel == 1); crit_we_i = (sel == 2);
        tick();
    endtask

    task automatic set_q(input int q);
        temp_i = 16'(q * 4 + ((q & 32'h7fff) % 4));
    endtask

    // ramp up then down through the window, with periodic clears
    task automatic sweep(input logic [15:0] cfgv);
        int k;
        k = 0;
        wr_cfg(cfgv);
        for (int q = -20; q <= 230; q++) begin
            set_q(q);
            k++;
            if (k % 9 == 0) clr_evt_i = 1;
            if (k % 13 == 0) begin wdata_i = cfgv | 16'h0020; cfg_we_i = 1; end
            tick();
        end
        for (int q = 230; q >= -20; q--) begin
            set_q(q);
            k++;
            if (k % 9 == 0) clr_evt_i = 1;
            if (k % 13 == 0) begin wdata_i = cfgv | 16'h0020; cfg_we_i = 1; end
            tick();
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_mode = 0; m_pol = 0; m_conly = 0; m_oe = 0; m_lka = 0; m_lkc = 0; m_shdn = 0;
        m_hyst = 0; m_up = 0; m_lo = 0; m_cr = 0;
        m_above = 0; m_below = 0; m_crit = 0; m_latch = 0; m_evt = 0;
        temp_i = 16'd100;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1", "flags", {13'b0, crit_o, below_o, above_o}, 16'h0);
        chk("R1", "evt_status", 16'(evt_status_o), 16'h0);
        chk("R1", "cfg_rd", cfg_rd_o, 16'h0);
        chk("R1", "pin", 16'(evt_pin_o), 16'h1);
        chk("R1", "upper_rd", upper_rd_o, 16'h0);

        // R2 field masking and signed limits
        cur_req = "R2";
        wr_lim(0, 16'hFFFF);
        chk("R2", "upper masked", upper_rd_o, 16'h1FFC);
        wr_lim(1, 16'hE003);
        chk("R2", "lower masked", lower_rd_o, 16'h0000);
        wr_lim(0, 16'(120 << 2));
        wr_lim(1, 16'(40 << 2));
        wr_lim(2, 16'(200 << 2));

        // comparator and interrupt modes at every hysteresis, varying polarity/enable
        for (int hy = 0; hy < 4; hy++) begin
            cur_req = "R6";
            sweep(16'((hy << 9) | ((hy & 1) << 1) | ((hy != 3) ? 8 : 0)));
            cur_req = "R7";
            sweep(16'((hy << 9) | (((hy >> 1) & 1) << 1) | 8 | 1));
        end
        // critical-only in both modes
        cur_req = "R8";
        sweep(16'((2 << 9) | 8 | 4));
        sweep(16'((1 << 9) | 8 | 4 | 1));

        // negative limits exercise signed compare
        cur_req = "R4";
        wr_lim(1, 16'h1FE0);   // -8 quarter units
        sweep(16'((1 << 9) | 8));
        wr_lim(1, 16'(40 << 2));

        // R7 same-cycle set and clear: set wins
        cur_req = "R7";
        wr_cfg(16'h0009);
        set_q(60); tick(); tick();
        set_q(130); clr_evt_i = 1; tick();
        chk("R7", "set beats clear", 16'(evt_status_o), 16'h1);
        set_q(60); tick();
        clr_evt_i = 1; tick();
        chk("R7", "cleared", 16'(evt_status_o), 16'h0);

        // R11 shutdown holds state
        cur_req = "R11";
        set_q(60); wr_cfg(16'h0008); tick();
        wr_cfg(16'h0108);
        set_q(240); tick(); tick(); clr_evt_i = 1; tick();
        chk("R11", "held crit", 16'(crit_o), 16'h0);
        set_q(10); tick();
        wr_cfg(16'h0008);
        set_q(240); tick();
        chk("R11", "resumed crit", 16'(crit_o), 16'h1);
        set_q(60); tick(); tick();

        // R10 locks
        cur_req = "R10";
        wr_cfg(16'h00C9);
        wr_cfg(16'h0002);
        chk("R10", "mode kept", 16'(cfg_rd_o[0]), 16'h1);
        chk("R10", "pol kept", 16'(cfg_rd_o[1]), 16'h0);
        wr_lim(0, 16'(150 << 2));
        chk("R10", "upper locked", upper_rd_o, 16'(120 << 2));
        wr_lim(2, 16'(210 << 2));
        chk("R10", "crit locked", crit_rd_o, 16'(200 << 2));
        wr_cfg(16'h0000);
        chk("R10", "locks sticky", 16'(cfg_rd_o[7:6]), 16'h3);
        set_q(130); tick(); set_q(60); tick(); tick();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule